// File: doc/BRIEF.md
# Input-State History Detector

This block watches a pair of level inputs, `x1In` and `x2In`, and raises `matchOut` when a particular run of input states has just been seen. The pair is read as a two-bit value `{x1In, x2In}`. A state counts as one step no matter how long it is held, so the detector responds to a change in the pair and not to the passing of clock cycles. A synchronous design can therefore behave like a fundamental-mode asynchronous network without any hazard analysis.

Both inputs first pass through a synchroniser chain. A change detector compares the synchronised pair with the last pair it accepted. A tracking state machine steps once per accepted change. The output is a decode of the tracking state (Moore style). If both inputs are ever seen high together, which is an illegal combination, the tracker drops back to idle and a one-cycle flag reports the event.

Top module: `seqdet_top`

## Requirements
- R1: With the default of two synchroniser stages, a change on the inputs reaches `matchOut` on the third rising clock edge after it is applied, and not on the second.
- R2: `matchOut` is high only while the accepted input pair is 01 (`x1In`=0, `x2In`=1).
- R3: `matchOut` goes high when the list of distinct accepted pairs ends, oldest first, with 01, 00, 10, 00, 10, 00, 01. Here `x1In` is the upper bit of each pair.
- R4: The tracker steps only when the synchronised pair differs from the last accepted pair. Holding any state for any number of cycles counts as one step.
- R5: The 01 that completes a match also counts as the first element of the next match, so matches may overlap.
- R6: Once set, `matchOut` stays high for as long as the pair stays at 01. It falls on the next accepted change.
- R7: A pair that breaks the expected order sends the tracker back to idle. When the breaking pair is 01, the tracker instead resumes as if it had seen only the first element.
- R8: An accepted pair of 11 returns the tracker to idle, clears the history seen so far, forces `matchOut` low and raises `errFlag` for exactly one cycle.
- R9: A synchronous active-high reset clears `matchOut`, `errFlag`, the tracker and the synchroniser, and sets the last accepted pair to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x1In | input | 1 | First input of the pair (upper bit) |
| x2In | input | 1 | Second input of the pair (lower bit) |
| matchOut | output | 1 | High while a completed history is being held at 01 |
| errFlag | output | 1 | One-cycle pulse when 11 is accepted |

## Verification
The bench builds the block with its default synchroniser depth of two stages. It derives the expected latency as that depth plus one, which makes the exact arrival edge of R1 a direct check. A depth this short allows every held state to last only four to eight cycles, so several hundred random single-bit walks fit in a short run, and random walks of that length complete the seven-state pattern often. Directed runs add the cases that random walks rarely produce: overlap, breaks at each position, long holds, illegal 11 entries and reset in the middle of a match.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A,
    ST_B,
    ST_C,
    ST_D,
    ST_E,
    ST_F,
    ST_HIT
  } trackState_t;

  // control -> datapath
  typedef struct packed {
    logic latchPair;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       changed;
    logic       illegal;
    logic [1:0] pair;
  } dpStatus_t;

  localparam logic [1:0] PAIR_LO   = 2'b00;
  localparam logic [1:0] PAIR_ONE  = 2'b01;
  localparam logic [1:0] PAIR_TWO  = 2'b10;
  localparam logic [1:0] PAIR_BAD  = 2'b11;

endpackage

// File: rtl/seqdet_datapath.sv
module seqdet_datapath
  import seqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        x1In,
  input  logic        x2In,
  input  ctrlStrobe_t ctl,
  output dpStatus_t   stat,
  output logic [1:0]  heldPair
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] syncChain [SYNC_STAGES];
  logic [1:0] prevSample;

  always_ff @(posedge clk) begin
    if (rst) syncChain[0] <= PAIR_LO;
    else     syncChain[0] <= {x1In, x2In};
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncChain[g] <= PAIR_LO;
        else     syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                prevSample <= PAIR_LO;
    else if (ctl.latchPair) prevSample <= syncChain[LAST];
  end

  always_comb begin
    stat.pair    = syncChain[LAST];
    stat.changed = (syncChain[LAST] != prevSample);
    stat.illegal = (syncChain[LAST] == PAIR_BAD);
  end

  assign heldPair = prevSample;

  // R4: an accepted pair is the one that was presented on the latch cycle
  p_prev_follows_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.latchPair |=> (prevSample == $past(stat.pair)));

  // R4: without a latch strobe the held pair does not move
  p_prev_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !ctl.latchPair |=> $stable(prevSample));

endmodule

// File: rtl/seqdet_control.sv
module seqdet_control
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   stat,
  output ctrlStrobe_t ctl,
  output logic        matchOut,
  output logic        errFlag
);

  trackState_t state, nextState;
  logic        errQ, errNext;

  function automatic logic [1:0] expectPair(trackState_t s);
    case (s)
      ST_IDLE: expectPair = PAIR_ONE;
      ST_A:    expectPair = PAIR_LO;
      ST_B:    expectPair = PAIR_TWO;
      ST_C:    expectPair = PAIR_LO;
      ST_D:    expectPair = PAIR_TWO;
      ST_E:    expectPair = PAIR_LO;
      ST_F:    expectPair = PAIR_ONE;
      default: expectPair = PAIR_LO;   // ST_HIT acts as ST_A
    endcase
  endfunction

  function automatic trackState_t advance(trackState_t s);
    case (s)
      ST_IDLE: advance = ST_A;
      ST_A:    advance = ST_B;
      ST_B:    advance = ST_C;
      ST_C:    advance = ST_D;
      ST_D:    advance = ST_E;
      ST_E:    advance = ST_F;
      ST_F:    advance = ST_HIT;
      default: advance = ST_B;         // overlap: HIT already holds the first 01
    endcase
  endfunction

  always_comb begin
    nextState = state;
    errNext   = 1'b0;
    if (stat.changed) begin
      if (stat.illegal) begin
        nextState = ST_IDLE;
        errNext   = 1'b1;
      end else if (stat.pair == expectPair(state)) begin
        nextState = advance(state);
      end else if (stat.pair == PAIR_ONE) begin
        nextState = ST_A;
      end else begin
        nextState = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nextState;
      errQ  <= errNext;
    end
  end

  assign ctl.latchPair = stat.changed;
  assign matchOut      = (state == ST_HIT);
  assign errFlag       = errQ;

  // R4: no accepted change, no step
  p_hold_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !stat.changed |=> $stable(state));

  // R8: the error flag never lasts two cycles
  p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
    errQ |=> !errQ);

  // R3: a hit is only entered on an accepted 01
  p_hit_on_one_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(matchOut) |-> ($past(stat.pair) == PAIR_ONE && $past(stat.changed)));

endmodule

// File: rtl/seqdet_top.sv
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic x1In,
  input  logic x2In,
  output logic matchOut,
  output logic errFlag
);

  ctrlStrobe_t ctl;
  dpStatus_t   stat;
  logic [1:0]  heldPair;

  seqdet_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .x1In     (x1In),
    .x2In     (x2In),
    .ctl      (ctl),
    .stat     (stat),
    .heldPair (heldPair)
  );

  seqdet_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .stat     (stat),
    .ctl      (ctl),
    .matchOut (matchOut),
    .errFlag  (errFlag)
  );

  // R2: output only while the accepted pair is 01
  p_z_at_one_r2: assert property (@(posedge clk) disable iff (rst)
    matchOut |-> (heldPair == PAIR_ONE));

  // R8: the error cycle never shows a match
  p_err_no_match_r8: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> !matchOut);

endmodule

// File: tb/seqdet_top_tb.sv
module seqdet_top_tb;

  localparam int SYNC_STAGES = 2;
  localparam int LATENCY     = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x1In = 1'b0;
  logic x2In = 1'b0;
  logic matchOut, errFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [1:0] hist [7];
  int         histLen = 0;
  logic [1:0] lastPair = 2'b00;

  always #5 clk = ~clk;

  seqdet_top #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst(rst), .x1In(x1In), .x2In(x2In),
    .matchOut(matchOut), .errFlag(errFlag)
  );

  function automatic bit modelZ();
    logic [1:0] pat [7] = '{2'b01, 2'b00, 2'b10, 2'b00, 2'b10, 2'b00, 2'b01};
    if (histLen < 7) return 1'b0;
    for (int i = 0; i < 7; i++)
      if (hist[i] != pat[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelPush(input logic [1:0] v);
    if (v == 2'b11) begin
      histLen = 0;
    end else begin
      for (int i = 0; i < 6; i++) hist[i] = hist[i+1];
      hist[6] = v;
      if (histLen < 7) histLen++;
    end
  endtask

  // drive a pair at a negedge, hold it n cycles, check Z and the error pulse
  task automatic drive(input logic [1:0] v, input int n, input string req);
    int  errCnt = 0;
    bit  isEvent = (v != lastPair);
    {x1In, x2In} = v;
    if (isEvent) modelPush(v);
    lastPair = v;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (errFlag) errCnt++;
    end
    check(matchOut, modelZ(), req);
    if (v == 2'b11 && isEvent) check(errCnt == 1, 1'b1, "R8 err pulse");
    else                       check(errCnt == 0, 1'b1, "R8 no err");
  endtask

  task automatic doReset();
    {x1In, x2In} = 2'b00;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    histLen  = 0;
    lastPair = 2'b00;
  endtask

  task automatic runPattern(input string req);
    drive(2'b01, 4, req); drive(2'b00, 4, req); drive(2'b10, 4, req);
    drive(2'b00, 4, req); drive(2'b10, 4, req); drive(2'b00, 4, req);
    drive(2'b01, 4, req);
  endtask

  initial begin
    logic [1:0] cur;
    logic [1:0] nxt;
    void'($urandom(32'd2718));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(matchOut, 1'b0, "R9 reset Z");
    check(errFlag,  1'b0, "R9 reset err");
    rst = 1'b0;
    @(negedge clk);

    // R3 full match; R6 held then dropped
    runPattern("R3 match");
    check(matchOut, 1'b1, "R3 direct");
    repeat (10) @(negedge clk);
    check(matchOut, 1'b1, "R6 held at 01");
    drive(2'b00, 4, "R6 drop");
    check(matchOut, 1'b0, "R6 drop direct");

    // R5 overlap: the last 01 starts the next match
    doReset();
    runPattern("R5 first");
    drive(2'b00, 4, "R5"); drive(2'b10, 4, "R5"); drive(2'b00, 4, "R5");
    drive(2'b10, 4, "R5"); drive(2'b00, 4, "R5"); drive(2'b01, 4, "R5");
    check(matchOut, 1'b1, "R5 overlap direct");

    // R7 break with 01 then restart from first element
    drive(2'b00, 4, "R7"); drive(2'b10, 4, "R7"); drive(2'b00, 4, "R7");
    drive(2'b01, 4, "R7 break by 01");
    check(matchOut, 1'b0, "R7 no hit on break");
    drive(2'b00, 4, "R7"); drive(2'b10, 4, "R7"); drive(2'b00, 4, "R7");
    drive(2'b10, 4, "R7"); drive(2'b00, 4, "R7"); drive(2'b01, 4, "R7 resume");
    check(matchOut, 1'b1, "R7 resumed hit");
    // R7 break by extra 10
    drive(2'b00, 4, "R7"); drive(2'b10, 4, "R7"); drive(2'b00, 4, "R7");
    drive(2'b10, 4, "R7"); drive(2'b00, 4, "R7"); drive(2'b10, 4, "R7 extra");
    drive(2'b00, 4, "R7"); drive(2'b01, 4, "R7 after extra");
    check(matchOut, 1'b0, "R7 extra 10 breaks");

    // R4 long holds count once
    doReset();
    drive(2'b01, 20, "R4"); drive(2'b00, 17, "R4"); drive(2'b10, 25, "R4");
    drive(2'b00, 4, "R4");  drive(2'b10, 30, "R4"); drive(2'b00, 9, "R4");
    drive(2'b01, 4, "R4 long holds");
    check(matchOut, 1'b1, "R4 hit after holds");

    // R8 illegal 11 mid-sequence clears the history
    doReset();
    drive(2'b01, 4, "R8"); drive(2'b00, 4, "R8"); drive(2'b10, 4, "R8");
    drive(2'b11, 4, "R8 illegal"); drive(2'b10, 4, "R8");
    drive(2'b00, 4, "R8"); drive(2'b10, 4, "R8"); drive(2'b00, 4, "R8");
    drive(2'b01, 4, "R8 after clear");
    check(matchOut, 1'b0, "R8 history cleared");
    // R8 11 while matched forces Z low
    doReset();
    runPattern("R8 pre");
    drive(2'b11, 4, "R8 during hit");
    check(matchOut, 1'b0, "R8 Z low on 11");

    // R1 exact arrival edge
    doReset();
    drive(2'b01, 4, "R1"); drive(2'b00, 4, "R1"); drive(2'b10, 4, "R1");
    drive(2'b00, 4, "R1"); drive(2'b10, 4, "R1"); drive(2'b00, 4, "R1");
    {x1In, x2In} = 2'b01;
    modelPush(2'b01);
    lastPair = 2'b01;
    repeat (LATENCY - 1) @(negedge clk);
    check(matchOut, 1'b0, "R1 not yet");
    @(negedge clk);
    check(matchOut, 1'b1, "R1 arrives");

    // R9 reset in the middle of a match attempt
    drive(2'b00, 4, "R9"); drive(2'b10, 4, "R9"); drive(2'b00, 4, "R9");
    drive(2'b10, 4, "R9"); drive(2'b00, 4, "R9");
    doReset();
    check(matchOut, 1'b0, "R9 after reset");
    drive(2'b01, 4, "R9 no stale history");
    check(matchOut, 1'b0, "R9 stale history gone");

    // random single-bit walks, R2 R3 R5 R6 R7 R8 against the history model
    doReset();
    cur = 2'b00;
    for (int k = 0; k < 500; k++) begin
      case (cur)
        2'b00:   nxt = ($urandom % 2) ? 2'b01 : 2'b10;
        2'b01:   nxt = ($urandom % 10 == 0) ? 2'b11 : 2'b00;
        2'b10:   nxt = ($urandom % 10 == 0) ? 2'b11 : 2'b00;
        default: nxt = ($urandom % 2) ? 2'b01 : 2'b10;
      endcase
      drive(nxt, 4 + int'($urandom % 5), "R2/R3 random");
      if (nxt != 2'b01) check(matchOut, 1'b0, "R2 random");
      cur = nxt;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule